// File: doc/BRIEF.md
# Stop-Mode On-Demand Clock Gating Controller

This block manages the clocks of a core domain while that domain is in stop. In normal running every domain clock is on: the core clock, the PLL, the external crystal oscillator, the internal 16 MHz RC oscillator and every peripheral clock gate. When stop is requested, all of these are shut off together. The regulator-mode output stays at main regulator mode in every state.

While the domain sits in stop, ten wakeup-capable serial peripherals can each ask for a clock so they can receive one frame. A request turns the internal RC oscillator on. Once the oscillator reports ready, its clock is gated through to the requesting peripherals and to no others. The peripheral then reports the frame as done, with or without a wakeup match. A frame that does not match drops that peripheral's clock. The oscillator switches off when no request is left, and the domain stays in stop. A matching frame raises a one-cycle wakeup pulse and returns the domain to running.

All pins are plain level control and status signals. No data flows through the block, so no port uses a valid/ready handshake and no back-pressure applies.

Top module: `stopclk_gate_ctrl`

## Requirements
- R1: After reset the domain is running: `core_clk_en`, `pll_en`, `xosc_en` and `rcosc_en` are 1, every bit of `periph_gate` is 1, and `wakeup` is 0.
- R2: `stop_req` high while running enters stop at the next clock edge. From then on `core_clk_en`, `pll_en`, `xosc_en` and `rcosc_en` are 0 and `periph_gate` is all zero until some peripheral requests a clock.
- R3: `reg_main` is 1 at all times, in running and in stop.
- R4: In stop, if `clk_req[i]` is high and channel i is not locked, `rcosc_en` is 1 after the next clock edge.
- R5: In stop, `periph_gate[i]` is 1 only while channel i holds an active request and `osc_rdy` is 1. All other gate bits stay 0.
- R6: Several channels may be active at once, and each gets its own gate. `rcosc_en` stays 1 until every active channel has released.
- R7: In stop, `frame_done[i]` with `wake_match[i]` low on an active channel clears that channel at the next edge. The domain stays in stop. The channel stays locked while `clk_req[i]` remains high and re-arms only after `clk_req[i]` goes low.
- R8: In stop, `frame_done[i]` with `wake_match[i]` high on an active channel returns the domain to running at the next edge. At that edge all clocks are re-enabled and `wakeup` is 1 for exactly one cycle.
- R9: `frame_done` and `wake_match` on a channel that is not active have no effect on any output.
- R10: Channel bits map as follows: bits 3..0 are the I2C controllers, bits 8..4 are the USARTs, and bit 9 is the low-power UART. Every channel behaves identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Request to enter stop, sampled while running |
| clk_req | input | 10 | Per-peripheral clock request in stop |
| frame_done | input | 10 | Per-peripheral frame-received flag |
| wake_match | input | 10 | Per-peripheral flag that the received frame is a wakeup frame |
| osc_rdy | input | 1 | Internal RC oscillator ready |
| core_clk_en | output | 1 | Core domain clock enable |
| pll_en | output | 1 | PLL enable |
| xosc_en | output | 1 | External oscillator enable |
| rcosc_en | output | 1 | Internal 16 MHz RC oscillator enable |
| periph_gate | output | 10 | Per-peripheral clock gate |
| reg_main | output | 1 | Regulator in main mode |
| wakeup | output | 1 | One-cycle pulse on a wakeup frame |

## Verification
Directed patterns cover these cases:
- A single request while the oscillator is not ready, which separates the oscillator vote from the gate.
- Two overlapping requesters, one of which releases early, which checks that each channel has its own gate and that the oscillator is held until the last request is released.
- A non-matching frame with the request left high, which separates a frame-driven release from a request-driven release.
- A frame flag on an idle channel and a matching frame on an active one, which separate an ignored event from a real wakeup.

Constrained random phases then re-enter stop repeatedly with random requests, frame flags, match flags and ready levels. A cycle model in the bench predicts every output on every cycle.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STOP = 1'b1
  } mode_t;

  localparam int unsigned N_I2C    = 4;
  localparam int unsigned N_USART  = 5;
  localparam int unsigned N_LPUART = 1;
endpackage

// File: rtl/stopclk_mode_fsm.sv
module stopclk_mode_fsm
  import stopclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_any,
  output logic in_stop,
  output logic wakeup
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      wakeup <= 1'b0;
    end else begin
      wakeup <= 1'b0;
      case (mode_q)
        MODE_RUN:  if (stop_req) mode_q <= MODE_STOP;
        MODE_STOP: if (wake_any) begin
          mode_q <= MODE_RUN;
          wakeup <= 1'b1;
        end
        default:   mode_q <= MODE_RUN;
      endcase
    end
  end

  assign in_stop = (mode_q == MODE_STOP);

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stop && stop_req) |=> in_stop);
  assert_wake_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && wake_any) |=> (!in_stop && wakeup));
  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |=> !wakeup);
endmodule

// File: rtl/stopclk_chan.sv
module stopclk_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stop,
  input  logic req,
  input  logic fdone,
  input  logic wmatch,
  input  logic osc_rdy,
  output logic active,
  output logic wake_hit,
  output logic gate
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lock_q <= 1'b0;
    end else if (!in_stop) begin
      active <= 1'b0;
      lock_q <= 1'b0;
    end else if (active && fdone && !wmatch) begin
      active <= 1'b0;
      lock_q <= 1'b1;
    end else if (!req) begin
      active <= 1'b0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      active <= 1'b1;
    end
  end

  assign wake_hit = active & fdone & wmatch;
  assign gate     = active & osc_rdy;

  assert_frame_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && active && fdone && !wmatch) |=> !active);
  assert_req_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && req && !lock_q && !(active && fdone)) |=> (active || !in_stop));
  assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !active && !req) |=> !active);
endmodule

// File: rtl/stopclk_gate_ctrl.sv
module stopclk_gate_ctrl
  import stopclk_pkg::*;
#(
  parameter int unsigned I2C_CNT    = N_I2C,
  parameter int unsigned USART_CNT  = N_USART,
  parameter int unsigned LPUART_CNT = N_LPUART,
  localparam int unsigned N_CH      = I2C_CNT + USART_CNT + LPUART_CNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic [N_CH-1:0] clk_req,
  input  logic [N_CH-1:0] frame_done,
  input  logic [N_CH-1:0] wake_match,
  input  logic            osc_rdy,
  output logic            core_clk_en,
  output logic            pll_en,
  output logic            xosc_en,
  output logic            rcosc_en,
  output logic [N_CH-1:0] periph_gate,
  output logic            reg_main,
  output logic            wakeup
);
  logic            in_stop;
  logic [N_CH-1:0] act;
  logic [N_CH-1:0] hit;
  logic [N_CH-1:0] gate;

  stopclk_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .wake_any (|hit),
    .in_stop  (in_stop),
    .wakeup   (wakeup)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    stopclk_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_stop  (in_stop),
      .req      (clk_req[i]),
      .fdone    (frame_done[i]),
      .wmatch   (wake_match[i]),
      .osc_rdy  (osc_rdy),
      .active   (act[i]),
      .wake_hit (hit[i]),
      .gate     (gate[i])
    );
  end

  assign core_clk_en = !in_stop;
  assign pll_en      = !in_stop;
  assign xosc_en     = !in_stop;
  assign rcosc_en    = !in_stop || (|act);
  assign periph_gate = in_stop ? gate : {N_CH{1'b1}};
  assign reg_main    = 1'b1;

  assert_gate_needs_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && (periph_gate != '0)) |-> (rcosc_en && osc_rdy));
  assert_stop_clocks_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && stop_req) |=> (!pll_en && !xosc_en && periph_gate == '0));
  assert_wake_clocks_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> (core_clk_en && pll_en && xosc_en));
endmodule

// File: tb/stopclk_gate_ctrl_tb_top.sv
module stopclk_gate_ctrl_tb_top;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0;
  logic [N-1:0] clk_req = '0, frame_done = '0, wake_match = '0;
  logic osc_rdy = 1'b0;
  logic core_clk_en, pll_en, xosc_en, rcosc_en, reg_main, wakeup;
  logic [N-1:0] periph_gate;

  int total = 0;
  int bad = 0;

  // bench model of the requirements
  logic m_run, m_wake;
  logic [N-1:0] m_act, m_lock;

  always #2 clk = ~clk;

  stopclk_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .clk_req(clk_req),
    .frame_done(frame_done), .wake_match(wake_match), .osc_rdy(osc_rdy),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .xosc_en(xosc_en),
    .rcosc_en(rcosc_en), .periph_gate(periph_gate), .reg_main(reg_main),
    .wakeup(wakeup)
  );

  function automatic logic [N+5:0] expect_out();
    logic [N-1:0] g;
    g = m_run ? {N{1'b1}} : (m_act & {N{osc_rdy}});
    return {m_run, m_run, m_run, (m_run | (|m_act)), g, 1'b1, m_wake};
  endfunction

  // advance model by one edge using the inputs now on the pins
  task automatic model_step();
    logic [N-1:0] hitv;
    logic [N-1:0] na, nl;
    hitv = m_act & frame_done & wake_match;
    na = m_act; nl = m_lock;
    m_wake = 1'b0;
    if (m_run) begin
      na = '0; nl = '0;
      if (stop_req) m_run = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_act[i] && frame_done[i] && !wake_match[i]) begin na[i] = 0; nl[i] = 1; end
        else if (!clk_req[i]) begin na[i] = 0; nl[i] = 0; end
        else if (!m_lock[i]) na[i] = 1;
      end
      if (|hitv) begin m_run = 1'b1; m_wake = 1'b1; na = '0; nl = '0; end
    end
    m_act = na; m_lock = nl;
  endtask

  task automatic check(input string tag);
    logic [N+5:0] act_v, exp_v;
    act_v = {core_clk_en, pll_en, xosc_en, rcosc_en, periph_gate, reg_main, wakeup};
    exp_v = expect_out();
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED1234));
    m_run = 1; m_wake = 0; m_act = '0; m_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R3 reset state");
    stop_req = 1; cycle("R2 enter stop");
    stop_req = 0; cycle("R2 R3 stop idle");
    clk_req[0] = 1; osc_rdy = 0; cycle("R4 osc vote without ready");
    osc_rdy = 1; #0; check("R5 gate only ch0 after ready");
    clk_req[5] = 1; cycle("R6 second requester");
    clk_req[0] = 0; cycle("R6 osc held by ch5");
    frame_done[5] = 1; cycle("R7 non-wakeup frame drops ch5");
    frame_done[5] = 0; cycle("R7 locked while request high");
    cycle("R7 still locked");
    frame_done[9] = 1; wake_match[9] = 1; cycle("R9 idle channel flags ignored");
    frame_done[9] = 0; wake_match[9] = 0;
    clk_req[5] = 0; cycle("R7 release clears lock");
    clk_req[5] = 1; clk_req[9] = 1; cycle("R7 R10 rearm ch5 and lpuart ch9");
    frame_done[9] = 1; wake_match[9] = 1; cycle("R8 wakeup frame exits stop");
    frame_done[9] = 0; wake_match[9] = 0; clk_req = '0; cycle("R8 wakeup one cycle");
    for (int r = 0; r < 40; r++) begin
      stop_req = 1; cycle("R2 random re-entry");
      stop_req = 0;
      for (int c = 0; c < 50; c++) begin
        clk_req    = N'($urandom) & N'($urandom);
        frame_done = N'($urandom) & N'($urandom) & N'($urandom);
        wake_match = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
        osc_rdy    = ($urandom_range(0, 3) != 0);
        stop_req   = ($urandom_range(0, 9) == 0);
        cycle("random R4 R5 R6 R7 R8 R9");
      end
      clk_req = '0; frame_done = '0; wake_match = '0; stop_req = 0;
      cycle("R3 random settle");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule